// File: doc/BRIEF.md
# Limit-Compare Tick Timer

This block is a microsecond tick counter that raises an interrupt each time its count reaches a programmed limit. A prescaler divides the system clock down to a one-microsecond tick. On every tick the count advances by one. When the count equals the limit it reloads to one, a sticky limit-reached flag is set and the interrupt output is raised. Software programs the limit and reads back the limit and count over a simple 32-bit word-addressed register bus. Both values sit in bits 31:10 of their words, so a microsecond count is written shifted left by ten.

Software acknowledges the interrupt by reading the limit word. A second word returns the same value without this side effect, so a debugger or a polling loop can look at the timer without losing an event. A parameter selects the variant. The per-processor variant, used for a profiling tick, adds a user control word whose bit 0 halts the counter. The system-wide variant, used for the periodic system tick, reads that word and the following one as zero.

Top module: `tick_limit_timer`

## Requirements
- R1: After reset, word 0 (limit) reads 0, word 1 (count) reads 1<<10, word 3 reads 0, and `irq` is low.
- R2: Outside a limit match or a bus write, the count grows by one every TICK_DIV clock cycles.
- R3: On a tick where the limit is nonzero and the count equals it, the count reloads to 1, bit 31 of word 0 becomes 1 and `irq` goes high on the next cycle. With limit L written, `irq` first rises L*TICK_DIV cycles after the write.
- R4: A read of word 0 clears the limit-reached flag, which drops `irq`, unless a new match happens in the same cycle.
- R5: Word 2 reads the same value as word 0, including bit 31, and reading it leaves `irq` unchanged.
- R6: A write to word 0 stores bits 30:10 as the limit, sets the count to 1, clears a pending interrupt and restarts the prescaler.
- R7: While the limit is 0, `irq` never rises and the count keeps running.
- R8: Bits 9:0 of words 0, 1 and 2 read as zero, and data written to those bits is ignored. Bit 31 of a limit write is also ignored.
- R9: In the per-processor variant, bit 0 of word 3 is a halt control. It reads back as written, and while it is 1 the count and prescaler hold their values.
- R10: A write to word 1 loads bits 31:10 into the count, and this takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per word |
| bus_rd | input | 1 | Read strobe; a read of word 0 acknowledges the interrupt |
| bus_addr | input | AW | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word, combinational |
| irq | output | 1 | Interrupt, high while the limit-reached flag is set |

## Verification
The assertions assume that reads and writes are single-cycle strobes. They also assume that a read of word 0 never coincides with a write, because the clear-on-read and clear-on-write checks exclude cycles where a bus write is present. The bench drives one access at a time on the falling clock edge, with the read and write strobes never both high. It times each access as a counted number of cycles after the most recent write, so the expected count and interrupt timing follow directly from the limit, TICK_DIV and the prescaler restart.

// File: rtl/tick_limit_timer.sv
module tick_limit_timer #(
  parameter int TICK_DIV = 125,
  parameter bit PER_CPU  = 1'b1,
  parameter int AW       = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int VW = 22;
  localparam int LW = VW - 1;
  localparam logic [AW-1:0] A_LIM = AW'(0);
  localparam logic [AW-1:0] A_CNT = AW'(1);
  localparam logic [AW-1:0] A_LNC = AW'(2);
  localparam logic [AW-1:0] A_USR = AW'(3);

  logic [PW-1:0] pre;
  logic [VW-1:0] cnt;
  logic [LW-1:0] lim;
  logic          flag;
  logic          halt;

  wire wr_lim = bus_wr && bus_addr == A_LIM;
  wire wr_cnt = bus_wr && bus_addr == A_CNT;
  wire rd_lim = bus_rd && bus_addr == A_LIM;
  wire tick   = !halt && pre == PW'(TICK_DIV - 1);
  wire hit    = tick && lim != '0 && cnt == {1'b0, lim};

  always_ff @(posedge clk) begin
    if (!rst_n)               pre <= '0;
    else if (wr_lim || tick)  pre <= '0;
    else if (!halt)           pre <= pre + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= VW'(1);
    else if (wr_lim) cnt <= VW'(1);
    else if (wr_cnt) cnt <= bus_wdata[31:10];
    else if (hit)    cnt <= VW'(1);
    else if (tick)   cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      lim <= '0;
    else if (wr_lim) lim <= bus_wdata[30:10];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      flag <= 1'b0;
    else if (wr_lim) flag <= 1'b0;
    else if (hit)    flag <= 1'b1;
    else if (rd_lim) flag <= 1'b0;
  end

  generate
    if (PER_CPU) begin : g_user
      always_ff @(posedge clk) begin
        if (!rst_n)                         halt <= 1'b0;
        else if (bus_wr && bus_addr == A_USR) halt <= bus_wdata[0];
      end
    end else begin : g_glob
      assign halt = 1'b0;
    end
  endgenerate

  assign irq = flag;

  always_comb begin
    case (bus_addr)
      A_LIM, A_LNC: bus_rdata = {flag, lim, 10'b0};
      A_CNT:        bus_rdata = {cnt, 10'b0};
      A_USR:        bus_rdata = {31'b0, halt};
      default:      bus_rdata = '0;
    endcase
  end

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !hit && !bus_wr |=> cnt == $past(cnt) + 1'b1);
  // R3
  match_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !bus_wr |=> cnt == VW'(1) && irq);
  // R4
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lim && !hit && !bus_wr |=> !irq);
  // R5
  noclear_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == A_LNC && irq && !bus_wr |=> irq);
  // R6
  limit_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lim |=> cnt == VW'(1) && !irq && lim == $past(bus_wdata[30:10]));
  // R7
  zero_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lim == '0 && !irq && !bus_wr |=> !irq);
  // R9
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt && !bus_wr |=> $stable(cnt) && $stable(pre));
endmodule

// File: tb/test_tick_limit_timer.sv
module test_tick_limit_timer;
  localparam int DIV = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq;
  int checks = 0, fails = 0, n = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  tick_limit_timer #(.TICK_DIV(DIV), .PER_CPU(1'b1), .AW(3)) i_tick_limit_timer (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  always #4 clk = ~clk;

  always @(negedge clk) begin
    #2;
    if (bus_rd) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL monitor: unexpected read actual=%h expected=none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          fails++;
          $display("FAIL %s addr=%0d actual=%h expected=%h", t, bus_addr, bus_rdata, e);
        end
      end
    end
  end

  task automatic step();
    @(negedge clk);
    n++;
  endtask

  task automatic wait_to(int t);
    while (n < t) step();
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_wr = 1'b0;
    n = 0;
  endtask

  task automatic bus_read(input logic [2:0] a, input logic [31:0] e, input string t);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    step();
    bus_rd = 1'b0;
  endtask

  task automatic check_irq(input logic e, input string t);
    #1;
    checks++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s irq actual=%b expected=%b", t, irq, e);
    end
  endtask

  function automatic logic [31:0] val(input int v);
    return 32'(v) << 10;
  endfunction

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check_irq(1'b0, "R1");
        bus_read(3'd0, 32'h0, "R1 limit");
        bus_read(3'd1, val(1), "R1 count");
        bus_read(3'd3, 32'h0, "R1 user");
        // R6 R8 limit write with junk low bits and bit 31
        bus_write(3'd0, 32'h8000_0000 | val(5) | 32'h3FF);
        bus_read(3'd0, val(5), "R6 R8 limit value");
        bus_read(3'd1, val(1), "R6 count reset");
        wait_to(8);  bus_read(3'd1, val(3), "R2 count");
        wait_to(11); bus_read(3'd1, val(3), "R2 count");
        wait_to(12); bus_read(3'd1, val(4), "R2 count");
        wait_to(19); check_irq(1'b0, "R3 before match");
        step();      check_irq(1'b1, "R3 at match");
        bus_read(3'd2, 32'h8000_0000 | val(5), "R5 noclear read");
        bus_read(3'd1, val(1), "R3 reload");
        check_irq(1'b1, "R5 irq kept");
        bus_read(3'd0, 32'h8000_0000 | val(5), "R4 ack read");
        check_irq(1'b0, "R4 irq cleared");
        bus_read(3'd0, val(5), "R4 flag cleared");
        // R6 limit write clears pending interrupt
        bus_write(3'd0, val(2));
        wait_to(8);  check_irq(1'b1, "R3 limit 2");
        bus_write(3'd0, val(7));
        check_irq(1'b0, "R6 write clears irq");
        bus_read(3'd1, val(1), "R6 count reset");
        // R7 zero limit
        bus_write(3'd0, 32'h0);
        wait_to(40); check_irq(1'b0, "R7 no irq");
        bus_read(3'd1, val(11), "R7 count runs");
        // R10 R8 count write
        bus_write(3'd1, val(100) | 32'h155);
        bus_read(3'd1, val(100), "R10 R8 count load");
        // R9 halt
        bus_write(3'd0, 32'h0);
        bus_write(3'd3, 32'h1);
        wait_to(20);
        bus_read(3'd1, val(1), "R9 count frozen");
        bus_read(3'd3, 32'h1, "R9 halt readback");
        bus_write(3'd3, 32'h0);
        bus_write(3'd0, val(3));
        wait_to(11); check_irq(1'b0, "R9 resume before match");
        step();      check_irq(1'b1, "R9 resume match");
        step();
        if (exp_q.size() != 0) begin
          checks++; fails++;
          $display("FAIL scoreboard: pending actual=%0d expected=0", exp_q.size());
        end
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule